// File: doc/BRIEF.md
# Legacy PC Memory Region Decoder

This block routes each CPU memory cycle of a 386-class AT system controller either to on-board memory or to the expansion I/O channel. It looks at the 20-bit physical address, whether the cycle is a read or a write, and seven internal 8-bit configuration registers. It then drives one of two mutually exclusive selects. The decoder handles two windows. The conventional window runs from 0x40000 to 0xBFFFF and is steered in 16 KB blocks. The upper window runs from 0xC0000 to 0xFFFFF. It holds option ROMs and BIOS, and each 16 KB block there can be sent to the channel outright. A block that is not sent to the channel follows a shadow code, held per 64 KB group, that picks the read route and the write route separately.

The configuration registers are loaded through a simple synchronous write port (`cfg_we`, `cfg_idx`, `cfg_wdata`). They clear to zero on reset. Address decoding is purely combinational from the address, the direction and the register contents. A register write therefore takes effect for cycles presented after the clock edge that captures it.

Top module: `mem_region_dec`

## Requirements
- R1: After reset every register is 0, so every active cycle at any address selects the board (`sel_board`=1, `sel_chan`=0) until a register is written.
- R2: While `mem_cyc` is 1, exactly one of `sel_board` and `sel_chan` is 1.
- R3: While `mem_cyc` is 0, both `sel_board` and `sel_chan` are 0.
- R4: Addresses below 0x40000 always select the board, whatever the configuration.
- R5: For 0x40000 to 0xBFFFF, let block n = (addr-0x40000)>>14 (0..31). Block n is steered by bit n%8 of register index 1+n/8.
- R6: A conventional block whose steering bit is 1 sends both reads and writes to the channel. A bit of 0 sends both to the board.
- R7: For 0xC0000 to 0xFFFFF, let block n = (addr-0xC0000)>>14 (0..15). Block n is steered by bit n%8 of register index 5+n/8. A 1 sends both reads and writes to the channel.
- R8: When an upper block's steering bit is 0, the group g = n/4 is routed by register index 0. Bit 3-g selects the route for reads and bit 7-g selects the route for writes, with 0 meaning board and 1 meaning channel. This gives all four read/write combinations per 64 KB group.
- R9: An upper block steering bit of 1 overrides the shadow code of its group.
- R10: A register write with `cfg_we`=1 is captured at the rising clock edge and applies from then on. Writes to index 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_idx | input | 3 | Register index: 0 shadow code, 1-4 conventional maps, 5-6 upper maps, 7 unused |
| cfg_wdata | input | 8 | Register write data |
| mem_cyc | input | 1 | Memory cycle active |
| mem_wr | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 20 | Physical address |
| sel_board | output | 1 | Route cycle to on-board memory |
| sel_chan | output | 1 | Route cycle to the expansion I/O channel |

## Verification
The assertions check on every cycle that the two selects are exclusive during a cycle and both low when idle. They also check that the low region always goes to the board, that an upper steering bit wins over the shadow code, and that the board is chosen before any register write. The correct bit for each of the 48 blocks, and the read and write routes for every shadow code, can only be shown by the bench. It sweeps all blocks in both directions under directed and random register contents and compares each result with an independent model. The bench also writes to the unused index and then checks that the routing has not changed.

// File: rtl/mem_region_dec.sv
module mem_region_dec #(
  parameter int ADDR_W  = 20,
  parameter int BLK_W   = 14,
  parameter int CONV_LO = 16,
  parameter int CONV_N  = 32,
  parameter int UP_N    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [7:0]        cfg_wdata,
  input  logic              mem_cyc,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              sel_board,
  output logic              sel_chan
);
  localparam int BN_W    = ADDR_W - BLK_W;
  localparam int UP_LO   = CONV_LO + CONV_N;
  localparam int CONV_R  = CONV_N / 8;
  localparam int UP_R    = UP_N / 8;

  logic [7:0]        shadow_q;
  logic [CONV_N-1:0] conv_map;
  logic [UP_N-1:0]   up_map;

  always_ff @(posedge clk) begin
    if (!rst_n) shadow_q <= '0;
    else if (cfg_we && cfg_idx == 3'd0) shadow_q <= cfg_wdata;
  end

  for (genvar i = 0; i < CONV_R; i++) begin : g_conv
    always_ff @(posedge clk) begin
      if (!rst_n) conv_map[i*8 +: 8] <= '0;
      else if (cfg_we && cfg_idx == 3'(1 + i)) conv_map[i*8 +: 8] <= cfg_wdata;
    end
  end

  for (genvar i = 0; i < UP_R; i++) begin : g_up
    always_ff @(posedge clk) begin
      if (!rst_n) up_map[i*8 +: 8] <= '0;
      else if (cfg_we && cfg_idx == 3'(1 + CONV_R + i)) up_map[i*8 +: 8] <= cfg_wdata;
    end
  end

  logic [BN_W-1:0] blk;
  logic            in_conv, in_up, route_chan;
  logic [4:0]      conv_n;
  logic [3:0]      up_n;
  logic [1:0]      grp;
  logic            shadow_sel;

  assign blk     = mem_addr[ADDR_W-1:BLK_W];
  assign in_conv = (blk >= BN_W'(CONV_LO)) && (blk < BN_W'(UP_LO));
  assign in_up   = (blk >= BN_W'(UP_LO));
  assign conv_n  = 5'(blk - BN_W'(CONV_LO));
  assign up_n    = 4'(blk - BN_W'(UP_LO));
  assign grp     = up_n[3:2];

  always_comb begin
    if (mem_wr) shadow_sel = shadow_q[3'd7 - {1'b0, grp}];
    else        shadow_sel = shadow_q[3'd3 - {1'b0, grp}];
  end

  always_comb begin
    route_chan = 1'b0;
    if (in_conv)    route_chan = conv_map[conv_n];
    else if (in_up) route_chan = up_map[up_n] | shadow_sel;
  end

  assign sel_chan  = mem_cyc & route_chan;
  assign sel_board = mem_cyc & ~route_chan;
endmodule

module mem_region_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        mem_cyc,
  input logic [19:0] mem_addr,
  input logic [15:0] up_map,
  input logic        sel_board,
  input logic        sel_chan
);
  logic any_wr;
  always_ff @(posedge clk) begin
    if (!rst_n) any_wr <= 1'b0;
    else if (cfg_we) any_wr <= 1'b1;
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cyc |-> $countones({sel_board, sel_chan}) == 1); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cyc |-> !sel_board && !sel_chan); // R3
  AST_LOW_BOARD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cyc && mem_addr < 20'h40000) |-> sel_board); // R4
  AST_STEER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cyc && mem_addr[19:18] == 2'b11 && up_map[mem_addr[17:14]]) |-> sel_chan); // R9
  AST_RESET_BOARD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cyc && !any_wr) |-> sel_board); // R1
endmodule

bind mem_region_dec mem_region_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mem_cyc(mem_cyc),
  .mem_addr(mem_addr), .up_map(up_map), .sel_board(sel_board), .sel_chan(sel_chan)
);

// File: tb/mem_region_dec_tb.sv
module mem_region_dec_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_idx = 0;
  logic [7:0] cfg_wdata = 0;
  logic mem_cyc = 0, mem_wr = 0;
  logic [19:0] mem_addr = 0;
  logic sel_board, sel_chan;
  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] m [0:6];

  always #4 clk = ~clk;

  mem_region_dec dut_i (.*);

  function automatic logic exp_chan(input logic [19:0] a, input logic w);
    int b, n, g;
    b = int'(a >> 14);
    if (b < 16) return 1'b0;
    if (b < 48) begin n = b - 16; return m[1 + n / 8][n % 8]; end
    n = b - 48;
    if (m[5 + n / 8][n % 8]) return 1'b1;
    g = n / 4;
    return w ? m[0][7 - g] : m[0][3 - g];
  endfunction

  task automatic cfg(input int idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (idx < 7) m[idx] = d;
  endtask

  task automatic chk(input logic [19:0] a, input logic w, input string req);
    logic e;
    mem_cyc = 1; mem_addr = a; mem_wr = w;
    #1;
    e = exp_chan(a, w);
    checks++;
    if (sel_chan !== e || sel_board !== !e) begin
      errors++;
      $display("FAIL %s addr=%05h wr=%0b chan=%0b board=%0b exp chan=%0b board=%0b",
               req, a, w, sel_chan, sel_board, e, !e);
    end
  endtask

  task automatic sweep(input string req);
    for (int b = 0; b < 64; b++)
      for (int w = 0; w < 2; w++)
        chk({b[5:0], 14'($urandom)}, w[0], req);
  endtask

  initial begin
    int s;
    s = $urandom(32'h5eed1234);
    for (int i = 0; i < 7; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (sel_board !== 0 || sel_chan !== 0) begin
      errors++; $display("FAIL R3 idle board=%0b chan=%0b exp 0 0", sel_board, sel_chan);
    end
    sweep("R1");
    mem_cyc = 0; #1;
    checks++;
    if (sel_board !== 0 || sel_chan !== 0) begin
      errors++; $display("FAIL R3 idle board=%0b chan=%0b exp 0 0", sel_board, sel_chan);
    end
    for (int k = 0; k < 32; k++) begin
      for (int r = 1; r < 5; r++) cfg(r, (r == 1 + k / 8) ? 8'(1 << (k % 8)) : 8'h00);
      sweep("R5");
    end
    for (int r = 1; r < 5; r++) cfg(r, 8'hFF);
    sweep("R6");
    for (int r = 1; r < 5; r++) cfg(r, 8'h00);
    for (int k = 0; k < 16; k++) begin
      cfg(5, (k < 8) ? 8'(1 << k) : 8'h00);
      cfg(6, (k >= 8) ? 8'(1 << (k - 8)) : 8'h00);
      sweep("R7");
    end
    cfg(5, 0); cfg(6, 0);
    for (int c = 0; c < 256; c++) begin
      cfg(0, 8'(c));
      sweep("R8");
    end
    cfg(5, 8'hFF); cfg(6, 8'hFF);
    sweep("R9");
    cfg(0, 8'h5A); cfg(5, 8'h0F); cfg(6, 8'hA0);
    cfg(7, 8'hFF);
    sweep("R10");
    for (int it = 0; it < 150; it++) begin
      for (int r = 0; r < 7; r++) cfg(r, 8'($urandom));
      sweep("R4");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule